// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Receive Queue

This block receives asynchronous serial characters on a single input line and places each one in a 32-entry queue. A programmable divider produces an oversampling tick at sixteen times the bit rate. A start bit is confirmed in its middle, and every later bit is sampled at its own centre. Each character is checked for parity, stop-bit level and the all-zero break pattern. The character is stored together with its status, so software always sees the error bits of the character it reads.

Software configures the frame through static inputs: character length, parity enable and sense, one or two stop bits, and the divider. The block reports its state through a registered character count and a not-empty flag. It raises an interrupt when the fill reaches a coded level. A second interrupt fires when data has been waiting on an idle line for a selectable number of character times. A sticky receive-error flag and a flow-control output complete the status. A single-cycle pop strobe moves the oldest entry to a registered read word, and a clear strobe empties the queue.

Top module: `uart_rx_top`

## Requirements
- R1: One bit lasts 16 × (div_i + 1) clock cycles. A start bit is accepted only if the synchronised line is still low at the eighth oversample tick after the falling edge, so a low pulse shorter than that stores nothing. Each later bit is sampled at the centre tick.
- R2: When char7_i is 1, seven data bits are received and data bit 7 of the stored word reads 0. When char7_i is 0, eight data bits are received.
- R3: When par_en_i is 1, one parity bit follows the data bits. par_odd_i = 1 requires an odd number of ones over the data and parity bits, and par_odd_i = 0 requires an even number. A mismatch sets the parity-error bit (bit 8).
- R4: When stop2_i is 1, two stop bits are checked; otherwise one is. Any stop bit sampled low sets the framing bit (bit 10), and reception resumes only after the line returns high.
- R5: A pop of a non-empty queue loads rd_word_o in the next cycle with the following layout: bit 12 = 1 (valid), bit 11 break, bit 10 framing, bit 9 overrun, bit 8 parity, bits [7:0] data. Entries come out in arrival order.
- R6: A frame whose data, parity and stop samples are all zero is stored as one entry of value 0x1C00 (valid, break and framing set, data zero, parity bit clear).
- R7: The queue holds 32 characters. A character that arrives while it is full is discarded, and bit 9 is set on the most recently stored entry.
- R8: count_o gives the number of stored characters and not_empty_o is 1 whenever count_o is non-zero. A pop lowers the count by one. clear_i empties the queue in one cycle.
- R9: trig_code_i values 0 to 5 select levels 1, 4, 8, 16, 24 and 32; codes 6 and 7 select 32. trig_irq_o is 1 while count_o is at or above the selected level.
- R10: When rts_en_i is 1, rts_o is 0 while count_o is at or above the trigger level and 1 below it. When rts_en_i is 0, rts_o stays 1.
- R11: idle_code_i values 0 to 3 select disabled, 3, 7 or 15 character times, where a character time is the configured frame length in bits × 16 ticks. idle_irq_o rises when the queue is non-empty and the receiver has been idle for that long. A pop, a newly stored character, a clear or code 0 drops it.
- R12: err_o is set when a character with a break, framing or parity error is stored, or when an overrun occurs. It stays set until clear_i.
- R13: A pop of an empty queue loads rd_word_o with 0, with the valid bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| div_i | input | 16 | Bit-rate divider value |
| char7_i | input | 1 | 1 = seven data bits, 0 = eight |
| stop2_i | input | 1 | 1 = two stop bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| trig_code_i | input | 3 | Coded fill-level trigger |
| idle_code_i | input | 2 | Coded idle timeout |
| rts_en_i | input | 1 | Enable fill-based flow control |
| pop_i | input | 1 | Read strobe, pops one entry |
| clear_i | input | 1 | Empties the queue and clears err_o |
| rd_word_o | output | 13 | Popped tagged word |
| count_o | output | 6 | Stored character count |
| not_empty_o | output | 1 | Queue holds data |
| trig_irq_o | output | 1 | Fill level reached |
| idle_irq_o | output | 1 | Idle timeout with data waiting |
| err_o | output | 1 | Sticky receive-error flag |
| rts_o | output | 1 | Ready-to-receive output, 1 = send allowed |

## Verification
The bench builds the block with its default parameters: 32 entries, 16× oversampling and a 16-bit divider. These values make the top trigger level of 32 and the full-queue overrun reachable in a few thousand cycles. The bench drives divider values 0 and 1 at run time, so a bit lasts 16 or 32 cycles. Every frame shape, the break case and a full 33-character overrun therefore fit in a short run, and a 480-cycle idle window makes the timeout observable.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int WORD_W    = 13;
  localparam int ENTRY_W   = 12;
  localparam int BIT_VALID = 12;
  localparam int BIT_BRK   = 11;
  localparam int BIT_FRM   = 10;
  localparam int BIT_OVR   = 9;
  localparam int BIT_PAR   = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt >= div_i) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               rx_i,
  input  logic               char7_i,
  input  logic               stop2_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [ENTRY_W-1:0] word_o
);
  localparam int PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OSR / 2 - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

  rx_state_e    state;
  logic [PH_W-1:0] ph;
  logic [2:0]   bidx;
  logic [7:0]   shreg;
  logic         par_bit;
  logic         stop_bad;
  logic         second;

  logic         bad_now, brk_now, par_err_now;
  logic [2:0]   last_idx;
  logic [ENTRY_W-1:0] word_n;

  always_comb begin
    last_idx    = char7_i ? 3'd6 : 3'd7;
    bad_now     = stop_bad | ~rx_i;
    brk_now     = (shreg == 8'h00) && !(par_en_i && par_bit) && bad_now;
    par_err_now = par_en_i && !brk_now && ((^shreg ^ par_bit) != par_odd_i);
    word_n      = {brk_now, bad_now, 1'b0, par_err_now, shreg};
  end

  assign busy_o = (state != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      ph       <= '0;
      bidx     <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      stop_bad <= 1'b0;
      second   <= 1'b0;
      done_o   <= 1'b0;
      word_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (tick_i && !rx_i) begin
            state <= RX_START;
            ph    <= '0;
          end
        end
        RX_START: begin
          if (tick_i) begin
            if (ph == PH_MID) begin
              ph <= '0;
              if (!rx_i) begin
                state    <= RX_DATA;
                bidx     <= '0;
                shreg    <= '0;
                par_bit  <= 1'b0;
                stop_bad <= 1'b0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick_i) begin
            if (ph == PH_LAST) begin
              ph          <= '0;
              shreg[bidx] <= rx_i;
              if (bidx == last_idx) begin
                state  <= par_en_i ? RX_PAR : RX_STOP;
                second <= stop2_i;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
        RX_PAR: begin
          if (tick_i) begin
            if (ph == PH_LAST) begin
              ph      <= '0;
              par_bit <= rx_i;
              state   <= RX_STOP;
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick_i) begin
            if (ph == PH_LAST) begin
              ph <= '0;
              if (second) begin
                second   <= 1'b0;
                stop_bad <= bad_now;
              end else begin
                done_o <= 1'b1;
                word_o <= word_n;
                state  <= bad_now ? RX_HOLD : RX_IDLE;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
        RX_HOLD: begin
          if (rx_i) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push_i,
  input  logic [ENTRY_W-1:0] push_word_i,
  input  logic               pop_i,
  input  logic               clear_i,
  input  logic [2:0]         trig_code_i,
  input  logic               rts_en_i,
  output logic [WORD_W-1:0]  rd_word_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic               not_empty_o,
  output logic               trig_o,
  output logic               rts_o,
  output logic               ovr_o
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]   ovr_flags;
  logic [AW-1:0]      wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   cnt_n, level;
  logic               do_push, do_pop;
  int                 lvl_i;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] ptr_prev(input logic [AW-1:0] p);
    return (p == '0) ? LAST_PTR : p - 1'b1;
  endfunction

  always_comb begin
    do_push = push_i && !clear_i && (count_o < FULL_CNT);
    do_pop  = pop_i  && !clear_i && (count_o != '0);
    ovr_o   = push_i && !clear_i && (count_o == FULL_CNT);
    case (trig_code_i)
      3'd0:    lvl_i = 1;
      3'd1:    lvl_i = 4;
      3'd2:    lvl_i = 8;
      3'd3:    lvl_i = 16;
      3'd4:    lvl_i = 24;
      default: lvl_i = 32;
    endcase
    if (lvl_i > DEPTH) lvl_i = DEPTH;
    level = CNT_W'(lvl_i);
    cnt_n = count_o;
    if (clear_i) begin
      cnt_n = '0;
    end else begin
      if (do_push) cnt_n = cnt_n + 1'b1;
      if (do_pop)  cnt_n = cnt_n - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word_o <= '0;
    end else if (pop_i) begin
      if (do_pop)
        rd_word_o <= {1'b1, mem[rd_ptr][ENTRY_W-1:BIT_OVR+1],
                      mem[rd_ptr][BIT_OVR] | ovr_flags[rd_ptr],
                      mem[rd_ptr][BIT_OVR-1:0]};
      else
        rd_word_o <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      ovr_flags <= '0;
    end else begin
      if (do_push) ovr_flags[wr_ptr]           <= 1'b0;
      if (ovr_o)   ovr_flags[ptr_prev(wr_ptr)] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      count_o     <= '0;
      not_empty_o <= 1'b0;
      trig_o      <= 1'b0;
      rts_o       <= 1'b1;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count_o     <= cnt_n;
      not_empty_o <= (cnt_n != '0);
      trig_o      <= (cnt_n >= level);
      rts_o       <= !(rts_en_i && (cnt_n >= level));
    end
  end
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       busy_i,
  input  logic       hold_i,
  input  logic       restart_i,
  input  logic [1:0] code_i,
  input  logic       char7_i,
  input  logic       stop2_i,
  input  logic       par_en_i,
  output logic       flag_o
);
  localparam int PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

  logic [PH_W-1:0] ph;
  logic [7:0]      bits;
  logic [3:0]      fbits, mult;
  logic [7:0]      limit;
  logic            stop_clock;

  always_comb begin
    fbits = 4'd1 + (char7_i ? 4'd7 : 4'd8) + {3'b000, par_en_i} + (stop2_i ? 4'd2 : 4'd1);
    case (code_i)
      2'd1:    mult = 4'd3;
      2'd2:    mult = 4'd7;
      2'd3:    mult = 4'd15;
      default: mult = 4'd0;
    endcase
    limit      = {4'b0000, fbits} * {4'b0000, mult};
    stop_clock = restart_i || busy_i || !hold_i || (code_i == 2'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      bits   <= '0;
      flag_o <= 1'b0;
    end else if (stop_clock) begin
      ph   <= '0;
      bits <= '0;
      if (restart_i || !hold_i || (code_i == 2'd0)) flag_o <= 1'b0;
    end else if (tick_i) begin
      if (ph == PH_LAST) begin
        ph <= '0;
        if (bits + 8'd1 >= limit) flag_o <= 1'b1;
        else                      bits   <= bits + 8'd1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int OSR   = 16,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              char7_i,
  input  logic              stop2_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [2:0]        trig_code_i,
  input  logic [1:0]        idle_code_i,
  input  logic              rts_en_i,
  input  logic              pop_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic              not_empty_o,
  output logic              trig_irq_o,
  output logic              idle_irq_o,
  output logic              err_o,
  output logic              rts_o
);
  logic [1:0]         sync_q;
  logic               tick, busy, done, ovr;
  logic [ENTRY_W-1:0] frame_word;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd_i};
  end

  uart_rx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst(rst), .div_i(div_i), .tick_o(tick)
  );

  uart_rx_frame #(.OSR(OSR)) frame_i (
    .clk(clk), .rst(rst), .tick_i(tick), .rx_i(sync_q[1]),
    .char7_i(char7_i), .stop2_i(stop2_i), .par_en_i(par_en_i),
    .par_odd_i(par_odd_i), .busy_o(busy), .done_o(done), .word_o(frame_word)
  );

  uart_rx_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .push_i(done), .push_word_i(frame_word),
    .pop_i(pop_i), .clear_i(clear_i), .trig_code_i(trig_code_i),
    .rts_en_i(rts_en_i), .rd_word_o(rd_word_o), .count_o(count_o),
    .not_empty_o(not_empty_o), .trig_o(trig_irq_o), .rts_o(rts_o), .ovr_o(ovr)
  );

  uart_rx_idle #(.OSR(OSR)) idle_i (
    .clk(clk), .rst(rst), .tick_i(tick), .busy_i(busy), .hold_i(not_empty_o),
    .restart_i(done | pop_i | clear_i), .code_i(idle_code_i),
    .char7_i(char7_i), .stop2_i(stop2_i), .par_en_i(par_en_i), .flag_o(idle_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      err_o <= 1'b0;
    end else if (ovr || (done && (frame_word[BIT_BRK] | frame_word[BIT_FRM] | frame_word[BIT_PAR]))) begin
      err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int DEPTH = 32
) (
  input logic        clk,
  input logic        rst,
  input logic        pop_i,
  input logic        clear_i,
  input logic        rts_en_i,
  input logic [1:0]  idle_code_i,
  input logic [12:0] rd_word_o,
  input logic [$clog2(DEPTH+1)-1:0] count_o,
  input logic        not_empty_o,
  input logic        trig_irq_o,
  input logic        idle_irq_o,
  input logic        err_o,
  input logic        rts_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_o <= FULL_CNT);  // R7
  AST_NOT_EMPTY_MATCH: assert property (@(posedge clk) disable iff (rst)
    not_empty_o == (count_o != '0));  // R8
  AST_POP_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !clear_i && count_o != '0) |=> (count_o <= $past(count_o)));  // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (count_o == '0 && !err_o));  // R12
  AST_POP_VALID: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !clear_i && count_o != '0) |=> rd_word_o[12]);  // R5
  AST_POP_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pop_i && count_o == '0) |=> (rd_word_o == 13'd0));  // R13
  AST_RTS_FOLLOWS_TRIG: assert property (@(posedge clk) disable iff (rst)
    $past(rts_en_i) |-> (rts_o == !trig_irq_o));  // R10
  AST_IDLE_DISABLED: assert property (@(posedge clk) disable iff (rst)
    ($past(idle_code_i) == 2'd0) |-> !idle_irq_o);  // R11
endmodule

bind uart_rx_top uart_rx_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .pop_i(pop_i), .clear_i(clear_i), .rts_en_i(rts_en_i),
  .idle_code_i(idle_code_i), .rd_word_o(rd_word_o), .count_o(count_o),
  .not_empty_o(not_empty_o), .trig_irq_o(trig_irq_o), .idle_irq_o(idle_irq_o),
  .err_o(err_o), .rts_o(rts_o)
);

// File: tb/uart_rx_top_tb_top.sv
`timescale 1ns/1ps
module uart_rx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic [15:0] div = 16'd0;
  logic        char7 = 1'b0, stop2 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic [2:0]  trig_code = 3'd0;
  logic [1:0]  idle_code = 2'd0;
  logic        rts_en = 1'b0, pop = 1'b0, clear = 1'b0;
  logic [12:0] rd_word;
  logic [5:0]  count;
  logic        not_empty, trig_irq, idle_irq, err, rts;

  int n_chk = 0;
  int n_bad = 0;
  int bclk  = 16;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  uart_rx_top dut_i (
    .clk(clk), .rst(rst), .rxd_i(rxd), .div_i(div), .char7_i(char7),
    .stop2_i(stop2), .par_en_i(par_en), .par_odd_i(par_odd),
    .trig_code_i(trig_code), .idle_code_i(idle_code), .rts_en_i(rts_en),
    .pop_i(pop), .clear_i(clear), .rd_word_o(rd_word), .count_o(count),
    .not_empty_o(not_empty), .trig_irq_o(trig_irq), .idle_irq_o(idle_irq),
    .err_o(err), .rts_o(rts)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_div(input logic [15:0] d);
    div  = d;
    bclk = 16 * (int'(d) + 1);
  endtask

  task automatic tx_frame(input logic [7:0] d, input int nd, input logic flip,
                          input logic stopv);
    logic p;
    logic pbit;
    p = 1'b0;
    rxd = 1'b0;
    wait_clks(bclk);
    for (int i = 0; i < nd; i++) begin
      rxd = d[i];
      p   = p ^ d[i];
      wait_clks(bclk);
    end
    if (par_en) begin
      pbit = par_odd ? ~p : p;
      if (flip) pbit = ~pbit;
      rxd = pbit;
      wait_clks(bclk);
    end
    for (int s = 0; s < (stop2 ? 2 : 1); s++) begin
      rxd = stopv;
      wait_clks(bclk);
    end
    rxd = 1'b1;
    wait_clks(bclk);
  endtask

  task automatic do_pop(output logic [12:0] w);
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
    w = rd_word;
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 count after reset", 32'(count), 0);
    chk("R8 not_empty after reset", 32'(not_empty), 0);
    chk("R13 rd_word after reset", 32'(rd_word), 0);
    chk("R9 trig after reset", 32'(trig_irq), 0);
    chk("R10 rts after reset", 32'(rts), 1);
    chk("R11 idle after reset", 32'(idle_irq), 0);
    chk("R12 err after reset", 32'(err), 0);
  endtask

  task automatic t_basic8();
    logic [12:0] w;
    set_div(16'd0); char7 = 0; par_en = 0; stop2 = 0;
    tx_frame(8'hA5, 8, 0, 1);
    tx_frame(8'h3C, 8, 0, 1);
    chk("R8 count two frames", 32'(count), 2);
    chk("R8 not_empty two frames", 32'(not_empty), 1);
    do_pop(w);
    chk("R5 R1 first word 8N1", 32'(w), 32'h10A5);
    do_pop(w);
    chk("R5 second word order", 32'(w), 32'h103C);
    chk("R8 count drained", 32'(count), 0);
    chk("R12 no error on clean frames", 32'(err), 0);
  endtask

  task automatic t_char7();
    logic [12:0] w;
    char7 = 1; par_en = 1; par_odd = 0; stop2 = 1;
    tx_frame(8'h35, 7, 0, 1);
    tx_frame(8'hB5, 7, 0, 1);
    tx_frame(8'h35, 7, 1, 1);
    do_pop(w);
    chk("R2 R3 R4 seven bit even two stop", 32'(w), 32'h1035);
    do_pop(w);
    chk("R2 bit 7 reads zero", 32'(w), 32'h1035);
    do_pop(w);
    chk("R3 even parity error flagged", 32'(w), 32'h1135);
    chk("R12 err after parity error", 32'(err), 1);
    do_clear();
    chk("R12 err cleared by clear", 32'(err), 0);
  endtask

  task automatic t_odd_div1();
    logic [12:0] w;
    set_div(16'd1); char7 = 0; par_en = 1; par_odd = 1; stop2 = 0;
    tx_frame(8'h0F, 8, 0, 1);
    tx_frame(8'h0F, 8, 1, 1);
    do_pop(w);
    chk("R1 R3 odd parity at divider 1", 32'(w), 32'h100F);
    do_pop(w);
    chk("R3 odd parity error", 32'(w), 32'h110F);
    set_div(16'd0); par_en = 0;
    do_clear();
  endtask

  task automatic t_framing();
    logic [12:0] w;
    tx_frame(8'h55, 8, 0, 0);
    do_pop(w);
    chk("R4 framing error on low stop", 32'(w), 32'h1455);
    chk("R12 err after framing", 32'(err), 1);
    do_clear();
  endtask

  task automatic t_break();
    logic [12:0] w;
    rxd = 1'b0;
    wait_clks(12 * bclk);
    rxd = 1'b1;
    wait_clks(3 * bclk);
    chk("R6 one entry for break", 32'(count), 1);
    do_pop(w);
    chk("R6 break word", 32'(w), 32'h1C00);
    chk("R12 err after break", 32'(err), 1);
    do_clear();
  endtask

  task automatic t_glitch();
    rxd = 1'b0;
    wait_clks(5);
    rxd = 1'b1;
    wait_clks(3 * bclk);
    chk("R1 short low pulse rejected", 32'(count), 0);
  endtask

  task automatic t_trigger();
    logic [12:0] w;
    rts_en = 1; trig_code = 3'd1;
    for (int i = 0; i < 3; i++) tx_frame(8'(i + 1), 8, 0, 1);
    chk("R9 below level 4", 32'(trig_irq), 0);
    chk("R10 rts high below level", 32'(rts), 1);
    tx_frame(8'h04, 8, 0, 1);
    chk("R9 at level 4", 32'(trig_irq), 1);
    chk("R10 rts low at level", 32'(rts), 0);
    do_pop(w);
    chk("R9 drops after pop", 32'(trig_irq), 0);
    chk("R10 rts back after pop", 32'(rts), 1);
    trig_code = 3'd0;
    wait_clks(2);
    chk("R9 code 0 level 1", 32'(trig_irq), 1);
    rts_en = 0;
    wait_clks(2);
    chk("R10 rts high when disabled", 32'(rts), 1);
    do_clear();
  endtask

  task automatic t_overrun();
    logic [12:0] w;
    trig_code = 3'd5;
    for (int i = 0; i < 32; i++) tx_frame(8'(i), 8, 0, 1);
    chk("R8 count full", 32'(count), 32);
    chk("R9 level 32 reached", 32'(trig_irq), 1);
    chk("R12 no err before overrun", 32'(err), 0);
    tx_frame(8'hEE, 8, 0, 1);
    chk("R7 count stays 32", 32'(count), 32);
    chk("R12 err on overrun", 32'(err), 1);
    for (int i = 0; i < 32; i++) begin
      do_pop(w);
      chk("R7 drained entry", 32'(w), (i == 31) ? 32'h121F : (32'h1000 | 32'(i)));
    end
    trig_code = 3'd0;
    do_clear();
  endtask

  task automatic t_pop_empty();
    logic [12:0] w;
    do_pop(w);
    chk("R13 pop of empty queue", 32'(w), 0);
  endtask

  task automatic t_timeout();
    logic [12:0] w;
    idle_code = 2'd0;
    tx_frame(8'h77, 8, 0, 1);
    wait_clks(700);
    chk("R11 disabled timeout stays low", 32'(idle_irq), 0);
    idle_code = 2'd1;
    wait_clks(400);
    chk("R11 before three char times", 32'(idle_irq), 0);
    wait_clks(200);
    chk("R11 after three char times", 32'(idle_irq), 1);
    do_pop(w);
    wait_clks(1);
    chk("R11 pop drops timeout", 32'(idle_irq), 0);
    chk("R5 word behind timeout", 32'(w), 32'h1077);
    idle_code = 2'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_clks(5);
    rst = 1'b0;
    wait_clks(2);
    t_reset();
    t_basic8();
    t_char7();
    t_odd_div1();
    t_framing();
    t_break();
    t_glitch();
    t_trigger();
    t_overrun();
    t_pop_empty();
    t_timeout();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule